// File: doc/BRIEF.md
# Cache Invalidation Command Registers

This block holds the two 64-bit invalidation command registers of a DMA address-remapping unit. Software accesses each register as two 32-bit words. One register flushes the context cache and the other flushes the translation TLB. To start a flush, software writes the upper word with the start bit set and a requested scope. The block then raises a request toward the external cache, holds it until the cache acknowledges, and then completes the command. On completion the block copies the requested scope into a separate "performed scope" field and clears the start bit. Software polls the start bit to learn when the flush has finished.

The context register sits at a fixed offset. The TLB register floats: its base is sixteen times a 10-bit unit field that software reads from a read-only extended capability word. A TLB command can also ask for outstanding DMA reads and/or writes to drain. In that case completion also waits for the pending-transaction tracker to report empty. Register reads are combinational on the address. Writes take effect on the clock edge.

Top module: `cache_inv_cmd`

## Requirements
- R1: After synchronous active-low reset, every register word reads 0 and both request outputs are low.
- R2: The capability word at offset 0x10 reads the TLB_UNIT parameter in bits 17:8 and 0 elsewhere. The TLB register low word is at 16*TLB_UNIT+8 and its upper word is at 16*TLB_UNIT+12.
- R3: When the context register is idle, a write to its upper word (0x2C) with bit 31 set starts a command on that edge. From the next cycle, bit 31 reads 1, bits 30:29 read the requested scope, bits 28:27 read 0, ctx_inv_req is high and ctx_inv_gran shows the scope. All other bits of the upper word read 0.
- R4: In the cycle ctx_inv_ack is sampled high during a context command, the busy bit and the request clear. Bits 28:27 then read the requested scope.
- R5: An idle TLB register started by an upper-word write with bit 31 set behaves as follows. Bits 29:28 hold the scope and bits 27:25 hold the performed scope as a zero-extended copy. Bit 17 is the read-drain flag and bit 16 is the write-drain flag. The scope appears on tlb_inv_gran, the drain flags appear on tlb_drain_rd and tlb_drain_wr, and tlb_inv_req rises.
- R6: A write to a low word (0x28, or TLB base+8) stores all 32 bits for readback and never starts a command.
- R7: While a register's busy bit is 1, writes to either of its words are ignored, and its request and scope outputs stay stable until acknowledge.
- R8: When either drain flag is set, tlb_inv_req drops the cycle after the acknowledge, but the busy bit stays 1 until pend_empty is sampled high. It clears on that edge.
- R9: An acknowledge that arrives while a register is idle has no effect.
- R10: An upper-word write with bit 31 clear on an idle register updates the stored scope (and the drain flags for the TLB). It starts nothing and leaves the performed-scope field unchanged.
- R11: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ctx_inv_req | output | 1 | Context-cache flush request |
| ctx_inv_gran | output | 2 | Requested context flush scope |
| ctx_inv_ack | input | 1 | Context flush done |
| tlb_inv_req | output | 1 | TLB flush request |
| tlb_inv_gran | output | 2 | Requested TLB flush scope |
| tlb_drain_rd | output | 1 | Drain pending reads before completion |
| tlb_drain_wr | output | 1 | Drain pending writes before completion |
| tlb_inv_ack | input | 1 | TLB flush done |
| pend_empty | input | 1 | No DMA transactions outstanding |

## Verification
The bench targets these corner cases:

- **Writes during a flush.** A design that accepts them would restart the command or change the scope shown to the cache.
- **Acknowledges while idle.** A design that honours them would overwrite the performed-scope field.
- **An acknowledge arriving before the drain has emptied.** The design must remember the acknowledge. One that forgets it would hang busy. One that ignores the drain would complete early.
- **Upper-word writes with the start bit clear.** They must not launch a request.
- **Low-word writes.** They must not trigger anything.
- **Reserved bits written as ones.** They must read back as zero.
- **Capability field and moved TLB address.** Read back together, these show whether the TLB register is decoded where the field says.

// File: rtl/cinv_pkg.sv
// Package: shared offsets, bit positions and the read-select type for the
// cache invalidation command registers. Assumes 32-bit register words.
package cinv_pkg;
    localparam int unsigned WORD_W       = 32;
    localparam int unsigned ECAP_OFF     = 32'h10;
    localparam int unsigned CTX_LO_OFF   = 32'h28;
    localparam int unsigned CTX_HI_OFF   = 32'h2C;
    localparam int unsigned TLB_LO_REL   = 8;
    localparam int unsigned TLB_HI_REL   = 12;
    localparam int unsigned START_BIT    = 31;
    localparam int unsigned UNIT_LSB     = 8;
    localparam int unsigned UNIT_W       = 10;
    localparam int unsigned SCOPE_W      = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ECAP,
        SEL_CTX_LO,
        SEL_CTX_HI,
        SEL_TLB_LO,
        SEL_TLB_HI
    } rd_sel_e;

    // Byte offset of the TLB register base for a given unit field value.
    function automatic int unsigned tlb_base(input int unsigned unit);
        return unit * 16;
    endfunction
endpackage

// File: rtl/cinv_decode.sv
// Address decoder: turns a word offset plus write strobe into per-word write
// enables and a read select. Assumes the TLB register does not overlap the
// fixed context and capability offsets.
module cinv_decode
    import cinv_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned TLB_UNIT = 10'h020
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              ctx_lo_wr,
    output logic              ctx_hi_wr,
    output logic              tlb_lo_wr,
    output logic              tlb_hi_wr,
    output rd_sel_e           sel
);
    localparam logic [ADDR_W-1:0] A_ECAP   = ADDR_W'(ECAP_OFF);
    localparam logic [ADDR_W-1:0] A_CTX_LO = ADDR_W'(CTX_LO_OFF);
    localparam logic [ADDR_W-1:0] A_CTX_HI = ADDR_W'(CTX_HI_OFF);
    localparam logic [ADDR_W-1:0] A_TLB_LO = ADDR_W'(tlb_base(TLB_UNIT) + TLB_LO_REL);
    localparam logic [ADDR_W-1:0] A_TLB_HI = ADDR_W'(tlb_base(TLB_UNIT) + TLB_HI_REL);

    // Purpose: map the offset onto one register word, fixed offsets first.
    always_comb begin
        if (addr == A_ECAP)        sel = SEL_ECAP;
        else if (addr == A_CTX_LO) sel = SEL_CTX_LO;
        else if (addr == A_CTX_HI) sel = SEL_CTX_HI;
        else if (addr == A_TLB_LO) sel = SEL_TLB_LO;
        else if (addr == A_TLB_HI) sel = SEL_TLB_HI;
        else                       sel = SEL_NONE;
    end

    // Purpose: qualify the selected word with the write strobe.
    always_comb begin
        ctx_lo_wr = wr && (sel == SEL_CTX_LO);
        ctx_hi_wr = wr && (sel == SEL_CTX_HI);
        tlb_lo_wr = wr && (sel == SEL_TLB_LO);
        tlb_hi_wr = wr && (sel == SEL_TLB_HI);
    end
endmodule

// File: rtl/cinv_channel.sv
// One invalidation command register (two 32-bit words) and its
// request/acknowledge handshake to an external cache. The busy bit (bit 31)
// is set by an upper-word write with bit 31 = 1 and cleared by hardware on
// completion, when the performed scope is copied from the requested one.
// With HAS_DRAIN, drain flags are held and completion also waits for
// pend_empty. All writes are ignored while busy. Acks while idle are ignored.
module cinv_channel
    import cinv_pkg::*;
#(
    parameter int unsigned GRAN_LSB  = 29,
    parameter int unsigned ACT_LSB   = 27,
    parameter int unsigned ACT_W     = 2,
    parameter bit          HAS_DRAIN = 1'b0,
    parameter int unsigned DRD_BIT   = 17,
    parameter int unsigned DWR_BIT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] lo_word,
    output logic [WORD_W-1:0] hi_word,
    output logic              inv_req,
    output logic [SCOPE_W-1:0] inv_gran,
    output logic              drain_rd,
    output logic              drain_wr,
    input  logic              inv_ack,
    input  logic              pend_empty
);
    logic                busy_q;
    logic                ack_seen_q;
    logic [SCOPE_W-1:0]  gran_q;
    logic [ACT_W-1:0]    act_q;
    logic [WORD_W-1:0]   lo_q;
    logic                drd_q;
    logic                dwr_q;
    logic                drain_ok;
    logic                finish;

    // Purpose: optional drain flags, present only on the TLB variant.
    generate
        if (HAS_DRAIN) begin : g_drain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    drd_q <= 1'b0;
                    dwr_q <= 1'b0;
                end else if (!busy_q && hi_wr) begin
                    drd_q <= wdata[DRD_BIT];
                    dwr_q <= wdata[DWR_BIT];
                end
            end
        end else begin : g_no_drain
            assign drd_q = 1'b0;
            assign dwr_q = 1'b0;
        end
    endgenerate

    // Purpose: decide whether the running command may complete this cycle.
    always_comb begin
        drain_ok = !(drd_q || dwr_q) || pend_empty;
        finish   = busy_q && (inv_ack || ack_seen_q) && drain_ok;
    end

    // Purpose: busy flag, remembered ack, requested and performed scope.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            ack_seen_q <= 1'b0;
            gran_q     <= '0;
            act_q      <= '0;
        end else if (busy_q) begin
            if (finish) begin
                busy_q     <= 1'b0;
                ack_seen_q <= 1'b0;
                act_q      <= ACT_W'(gran_q);
            end else if (inv_ack) begin
                ack_seen_q <= 1'b1;
            end
        end else if (hi_wr) begin
            gran_q <= wdata[GRAN_LSB +: SCOPE_W];
            if (wdata[START_BIT]) begin
                busy_q     <= 1'b1;
                ack_seen_q <= 1'b0;
                act_q      <= '0;
            end
        end
    end

    // Purpose: low word storage, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              lo_q <= '0;
        else if (!busy_q && lo_wr) lo_q <= wdata;
    end

    // Purpose: assemble the upper word for readback.
    always_comb begin
        hi_word                        = '0;
        hi_word[START_BIT]             = busy_q;
        hi_word[GRAN_LSB +: SCOPE_W]   = gran_q;
        hi_word[ACT_LSB +: ACT_W]      = act_q;
        if (HAS_DRAIN) begin
            hi_word[DRD_BIT] = drd_q;
            hi_word[DWR_BIT] = dwr_q;
        end
    end

    // Purpose: drive the cache-side handshake outputs.
    always_comb begin
        lo_word  = lo_q;
        inv_req  = busy_q && !ack_seen_q;
        inv_gran = gran_q;
        drain_rd = drd_q;
        drain_wr = dwr_q;
    end
endmodule

// File: rtl/cache_inv_cmd.sv
// Top: context-cache and TLB invalidation command registers with a
// capability word that locates the TLB register. Reads are combinational on
// reg_addr; writes act on the rising clock edge. Reset is synchronous, active low.
module cache_inv_cmd
    import cinv_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned TLB_UNIT = 10'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ctx_inv_req,
    output logic [1:0]        ctx_inv_gran,
    input  logic              ctx_inv_ack,
    output logic              tlb_inv_req,
    output logic [1:0]        tlb_inv_gran,
    output logic              tlb_drain_rd,
    output logic              tlb_drain_wr,
    input  logic              tlb_inv_ack,
    input  logic              pend_empty
);
    localparam logic [UNIT_W-1:0] UNIT_V = UNIT_W'(TLB_UNIT);

    logic        ctx_lo_wr, ctx_hi_wr, tlb_lo_wr, tlb_hi_wr;
    rd_sel_e     sel;
    logic [31:0] ctx_lo, ctx_hi, tlb_lo, tlb_hi, ecap_word;
    logic        ctx_drd_nc, ctx_dwr_nc;

    cinv_decode #(.ADDR_W(ADDR_W), .TLB_UNIT(TLB_UNIT)) u_dec (
        .addr(reg_addr), .wr(reg_wr),
        .ctx_lo_wr(ctx_lo_wr), .ctx_hi_wr(ctx_hi_wr),
        .tlb_lo_wr(tlb_lo_wr), .tlb_hi_wr(tlb_hi_wr),
        .sel(sel)
    );

    cinv_channel #(.GRAN_LSB(29), .ACT_LSB(27), .ACT_W(2), .HAS_DRAIN(1'b0)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(ctx_lo_wr), .hi_wr(ctx_hi_wr), .wdata(reg_wdata),
        .lo_word(ctx_lo), .hi_word(ctx_hi),
        .inv_req(ctx_inv_req), .inv_gran(ctx_inv_gran),
        .drain_rd(ctx_drd_nc), .drain_wr(ctx_dwr_nc),
        .inv_ack(ctx_inv_ack), .pend_empty(1'b1)
    );

    cinv_channel #(.GRAN_LSB(28), .ACT_LSB(25), .ACT_W(3), .HAS_DRAIN(1'b1),
                   .DRD_BIT(17), .DWR_BIT(16)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(tlb_lo_wr), .hi_wr(tlb_hi_wr), .wdata(reg_wdata),
        .lo_word(tlb_lo), .hi_word(tlb_hi),
        .inv_req(tlb_inv_req), .inv_gran(tlb_inv_gran),
        .drain_rd(tlb_drain_rd), .drain_wr(tlb_drain_wr),
        .inv_ack(tlb_inv_ack), .pend_empty(pend_empty)
    );

    // Purpose: read-only capability word carrying the TLB unit field.
    always_comb begin
        ecap_word                        = '0;
        ecap_word[UNIT_LSB +: UNIT_W]    = UNIT_V;
    end

    // Purpose: read multiplexer; unmapped offsets read zero.
    always_comb begin
        case (sel)
            SEL_ECAP:   reg_rdata = ecap_word;
            SEL_CTX_LO: reg_rdata = ctx_lo;
            SEL_CTX_HI: reg_rdata = ctx_hi;
            SEL_TLB_LO: reg_rdata = tlb_lo;
            SEL_TLB_HI: reg_rdata = tlb_hi;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cache_inv_cmd_chk.sv
// Checker: temporal properties on the ports of cache_inv_cmd, bound to it.
module cache_inv_cmd_chk
    import cinv_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned TLB_UNIT = 10'h020
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              ctx_inv_req,
    input logic [1:0]        ctx_inv_gran,
    input logic              ctx_inv_ack,
    input logic              tlb_inv_req,
    input logic [1:0]        tlb_inv_gran,
    input logic              tlb_drain_rd,
    input logic              tlb_drain_wr,
    input logic              tlb_inv_ack,
    input logic              pend_empty
);
    localparam logic [ADDR_W-1:0] A_CTX_HI = ADDR_W'(CTX_HI_OFF);
    localparam logic [ADDR_W-1:0] A_TLB_HI = ADDR_W'(tlb_base(TLB_UNIT) + TLB_HI_REL);

    assert_ctx_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctx_inv_req) |-> $past(reg_wr && reg_addr == A_CTX_HI && reg_wdata[31]));

    assert_ctx_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_inv_req && ctx_inv_ack) |=> !ctx_inv_req);

    assert_tlb_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlb_inv_req) |-> $past(reg_wr && reg_addr == A_TLB_HI && reg_wdata[31]));

    assert_ctx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_inv_req && !ctx_inv_ack) |=> (ctx_inv_req && $stable(ctx_inv_gran)));

    assert_tlb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_inv_req && !tlb_inv_ack) |=>
            (tlb_inv_req && $stable(tlb_inv_gran) && $stable(tlb_drain_rd) && $stable(tlb_drain_wr)));

    assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctx_inv_req && !(reg_wr && reg_addr == A_CTX_HI)) |=> !ctx_inv_req);
endmodule

bind cache_inv_cmd cache_inv_cmd_chk #(.ADDR_W(ADDR_W), .TLB_UNIT(TLB_UNIT)) u_chk (.*);

// File: tb/cache_inv_cmd_bench.sv
`timescale 1ns/1ps
module cache_inv_cmd_bench;
    localparam int unsigned AW   = 14;
    localparam int unsigned UNIT = 10'h020;
    localparam logic [AW-1:0] A_ECAP = 14'h10;
    localparam logic [AW-1:0] A_CLO  = 14'h28;
    localparam logic [AW-1:0] A_CHI  = 14'h2C;
    localparam logic [AW-1:0] A_TLO  = AW'(UNIT * 16 + 8);
    localparam logic [AW-1:0] A_THI  = AW'(UNIT * 16 + 12);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic cack = 1'b0, tack = 1'b0, pempty = 1'b1;
    logic [31:0] rdata;
    logic ctx_req, tlb_req, drd, dwr;
    logic [1:0] ctx_gran, tlb_gran;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cache_inv_cmd #(.ADDR_W(AW), .TLB_UNIT(UNIT)) u_cache_inv_cmd (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .ctx_inv_req(ctx_req), .ctx_inv_gran(ctx_gran),
        .ctx_inv_ack(cack), .tlb_inv_req(tlb_req), .tlb_inv_gran(tlb_gran),
        .tlb_drain_rd(drd), .tlb_drain_wr(dwr), .tlb_inv_ack(tack), .pend_empty(pempty)
    );

    // Reference model state, built from the requirements.
    logic       m_cb;  logic [1:0] m_cg; logic [1:0] m_ca; logic [31:0] m_cl;
    logic       m_tb;  logic m_ts; logic [1:0] m_tg; logic [2:0] m_ta; logic [31:0] m_tl;
    logic       m_dr, m_dw;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cb = 0; m_cg = 0; m_ca = 0; m_cl = 0;
            m_tb = 0; m_ts = 0; m_tg = 0; m_ta = 0; m_tl = 0; m_dr = 0; m_dw = 0;
        end else begin
            if (m_cb) begin
                if (cack) begin m_cb = 0; m_ca = m_cg; end
            end else begin
                if (wr && addr == A_CLO) m_cl = wdata;
                if (wr && addr == A_CHI) begin
                    m_cg = wdata[30:29];
                    if (wdata[31]) begin m_cb = 1; m_ca = 0; end
                end
            end
            if (m_tb) begin
                if ((tack || m_ts) && (!(m_dr || m_dw) || pempty)) begin
                    m_tb = 0; m_ts = 0; m_ta = {1'b0, m_tg};
                end else if (tack) m_ts = 1;
            end else begin
                if (wr && addr == A_TLO) m_tl = wdata;
                if (wr && addr == A_THI) begin
                    m_tg = wdata[29:28]; m_dr = wdata[17]; m_dw = wdata[16];
                    if (wdata[31]) begin m_tb = 1; m_ta = 0; m_ts = 0; end
                end
            end
        end
    end

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
        logic [31:0] w;
        w = '0;
        if (a == A_ECAP)     w[17:8] = UNIT[9:0];
        else if (a == A_CLO) w = m_cl;
        else if (a == A_CHI) begin w[31] = m_cb; w[30:29] = m_cg; w[28:27] = m_ca; end
        else if (a == A_TLO) w = m_tl;
        else if (a == A_THI) begin
            w[31] = m_tb; w[29:28] = m_tg; w[27:25] = m_ta; w[17] = m_dr; w[16] = m_dw;
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                         input logic ca, input logic ta);
        @(negedge clk);
        wr = w; addr = a; wdata = d; cack = ca; tack = ta;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a);
        drive(1'b0, a, 32'h0, 1'b0, 1'b0);
        #1;
        check(tag, rdata, exp_word(a));
    endtask

    task automatic outs(input string tag);
        check(tag, {26'b0, ctx_req, ctx_gran, tlb_req, tlb_gran, drd, dwr} >> 0,
              {26'b0, m_cb, m_cg, m_tb & ~m_ts, m_tg, m_dr, m_dw} >> 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd("R1 ctx hi", A_CHI); check("R1 ctx hi literal", rdata, 32'h0);
        rd("R1 tlb hi", A_THI); rd("R1 ctx lo", A_CLO); rd("R1 tlb lo", A_TLO);
        outs("R1 outputs");
        // R2: capability field
        rd("R2 ecap", A_ECAP); check("R2 ecap literal", rdata, 32'h0000_2000);
        // R11: unmapped offsets
        rd("R11 unmapped", 14'h30);
        drive(1'b1, 14'h30, 32'hFFFF_FFFF, 1'b0, 1'b0);
        drive(1'b1, 14'h2C + 14'h100, 32'hFFFF_FFFF, 1'b0, 1'b0);
        rd("R11 ctx hi unchanged", A_CHI); outs("R11 no request");
        // R6: low word stores, no trigger
        drive(1'b1, A_TLO, 32'hDEAD_BEEF, 1'b0, 1'b0);
        rd("R6 tlb lo", A_TLO); check("R6 tlb lo literal", rdata, 32'hDEAD_BEEF);
        outs("R6 no request");
        // R3: start context flush, global scope, reserved ones ignored
        drive(1'b1, A_CHI, 32'hBFFF_FFFF & ~32'h4000_0000, 1'b0, 1'b0);
        rd("R3 ctx hi", A_CHI); check("R3 ctx hi literal", rdata, 32'hA000_0000);
        outs("R3 outputs");
        // R7: writes while busy ignored
        drive(1'b1, A_CHI, 32'hE000_0000, 1'b0, 1'b0);
        drive(1'b1, A_CLO, 32'h1234_5678, 1'b0, 1'b0);
        rd("R7 ctx hi", A_CHI); rd("R7 ctx lo", A_CLO); outs("R7 outputs");
        // R4: acknowledge completes
        drive(1'b0, A_CHI, 32'h0, 1'b1, 1'b0);
        rd("R4 ctx hi", A_CHI); check("R4 ctx hi literal", rdata, 32'h2800_0000);
        outs("R4 outputs");
        // R9: ack while idle
        drive(1'b0, A_CHI, 32'h0, 1'b1, 1'b1);
        rd("R9 ctx hi", A_CHI); rd("R9 tlb hi", A_THI); outs("R9 outputs");
        // R5 / R8: TLB with both drains, ack before empty
        pempty = 1'b0;
        drive(1'b1, A_THI, 32'hA003_0000, 1'b0, 1'b0);
        rd("R5 tlb hi", A_THI); check("R5 tlb hi literal", rdata, 32'hA003_0000);
        outs("R5 outputs");
        drive(1'b0, A_THI, 32'h0, 1'b0, 1'b1);
        rd("R8 busy after ack", A_THI); outs("R8 req dropped");
        check("R8 req low", {31'b0, tlb_req}, 32'h0);
        rd("R8 still busy", A_THI);
        pempty = 1'b1;
        rd("R8 done", A_THI); rd("R8 done 2", A_THI);
        check("R8 done literal", rdata, 32'h2403_0000);
        // R10: upper write without start
        drive(1'b1, A_THI, 32'h1002_0000, 1'b0, 1'b0);
        rd("R10 tlb hi", A_THI); outs("R10 no request");
        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [AW-1:0] a;
            op = $urandom_range(0, 6);
            case (op)
                0: a = A_CHI; 1: a = A_THI; 2: a = A_CLO; 3: a = A_TLO;
                default: a = A_CHI;
            endcase
            pempty = ($urandom_range(0, 3) != 0);
            if (op <= 3) drive(1'b1, a, $urandom(), 1'b0, 1'b0);
            else if (op == 4) drive(1'b0, a, 32'h0, 1'b1, 1'b0);
            else if (op == 5) drive(1'b0, a, 32'h0, 1'b0, 1'b1);
            else drive(1'b0, a, 32'h0, $urandom_range(0, 1), $urandom_range(0, 1));
            rd("R3/R4 random ctx hi", A_CHI);
            rd("R5/R8 random tlb hi", A_THI);
            outs("R7 random outputs");
        end
        rd("R6 random ctx lo", A_CLO);
        rd("R6 random tlb lo", A_TLO);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule